// File: doc/BRIEF.md
# Programmable Video Sync and Blank Timing Generator

This block generates raster timing for a display from a divided dot clock, which has no fixed relationship to any system clock. A horizontal counter steps once per divided clock and a vertical counter steps once per line. Each axis has four programmable limits: where sync ends, where blanking ends, where blanking starts again, and the last count of the period. From these limits the block produces active-low sync and blank signals.

A control register sets the role of each sync pin. The pin can be driven by the block. It can also be treated as an input, and then a falling edge on the external signal, after synchronization, forces the matching counter back to zero, so that repaints follow external timing. The same register sets what the two shared output pins carry. The line pin carries either horizontal blank or composite sync. The frame pin carries either vertical blank or composite blank. Reset sets both sync pins to input and sets the shared pins to the two plain blanks.

Top module: `video_sync_gen`

## Requirements
- R1: The horizontal counter runs 0, 1, ..., total and then returns to 0, so a line lasts total+1 divided clocks.
- R2: The horizontal sync output is low while the horizontal count is below sync-end. Horizontal blank is active (low) while the count is below blank-end or at or above blank-start.
- R3: The vertical counter advances once, on the clock where the horizontal counter wraps, and wraps after its own total. Vertical sync and vertical blank follow the rules of R2, applied to the line count.
- R4: Control register bit 0 makes the horizontal sync pin an output and bit 1 does the same for the vertical pin. Each output-enable pin follows its bit.
- R5: With a sync pin in input mode, a falling edge on it passes through a two-stage synchronizer and resets the matching counter. If the low level is first sampled at clock edge n, the counter is zero after edge n+2, and the outputs show count zero after edge n+3.
- R6: With a sync pin in output mode, activity on its input has no effect on the counters.
- R7: Control bit 2 selects what the line output carries: 0 gives horizontal blank, 1 gives composite sync, which is low when either sync is active.
- R8: Control bit 3 selects what the frame output carries: 0 gives vertical blank, 1 gives composite blank, which is low when either blank is active.
- R9: Synchronous active-high reset clears all timing limits and the control register. While reset is high, all sync and shared outputs are high and both output enables are low. After reset, the line output carries horizontal blank.
- R10: Register map. Address bit 3 = 0 selects a timing limit. Address bit 2 selects the axis (0 horizontal, 1 vertical). Address bits 1:0 select sync-end (0), blank-end (1), blank-start (2) or total (3). Address 8 is the control register. Writes to addresses 9 through 15 are ignored.
- R11: Every output is registered, one clock after the counter state it reflects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided dot clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| hsync_i | input | 1 | External horizontal sync, active low |
| hsync_o | output | 1 | Generated horizontal sync, active low |
| hsync_oe | output | 1 | Drive enable for the horizontal sync pin |
| vsync_i | input | 1 | External vertical sync, active low |
| vsync_o | output | 1 | Generated vertical sync, active low |
| vsync_oe | output | 1 | Drive enable for the vertical sync pin |
| hmix_n | output | 1 | Horizontal blank or composite sync, active low |
| vmix_n | output | 1 | Vertical blank or composite blank, active low |

## Verification
A table of horizontal limit sets is walked, each with a sample phase taken after an external resync. Phases sit just before and just after every limit and past the wrap, which separates the strict-less-than sync and blank-end compares from the at-or-above blank-start compare. A short line then lets vertical phases be sampled several lines apart. This shows that the vertical count advances only on line wraps. Composite modes are sampled at phases where only one of the two merged signals is active, so that an AND and an OR of the two can be told apart. Falling edges applied in output mode, and a write to an unused address, are then checked at phases where a wrongful reset or an aliased write would flip the output.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'd8;

  localparam int F_SYNC_END    = 0;
  localparam int F_BLANK_END   = 1;
  localparam int F_BLANK_START = 2;
  localparam int F_TOTAL       = 3;
  localparam int N_FIELDS      = 4;
  localparam int N_AXES        = 2;
  localparam int AX_H          = 0;
  localparam int AX_V          = 1;

  typedef struct packed {
    logic cblank_sel;
    logic csync_sel;
    logic v_drive;
    logic h_drive;
  } ctrl_t;
endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
  import vsg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         we,
  input  logic [ADDR_W-1:0]                            addr,
  input  logic [CNT_W-1:0]                             wdata,
  output logic [N_AXES-1:0][N_FIELDS-1:0][CNT_W-1:0]   tim_o,
  output ctrl_t                                        ctrl_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      tim_o  <= '0;
      ctrl_o <= '0;
    end else if (we) begin
      if (!addr[3])
        tim_o[addr[2]][addr[1:0]] <= wdata;
      else if (addr == CTRL_ADDR)
        ctrl_o <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end
endmodule

// File: rtl/vsg_edge_sync.sv
module vsg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/vsg_axis.sv
module vsg_axis #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             resync,
  input  logic [CNT_W-1:0] sync_end,
  input  logic [CNT_W-1:0] blank_end,
  input  logic [CNT_W-1:0] blank_start,
  input  logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             sync_act,
  output logic             blank_act
);
  logic at_end;

  assign at_end = (cnt == total);
  assign wrap   = advance & at_end;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (resync)
      cnt <= '0;
    else if (advance)
      cnt <= at_end ? '0 : cnt + 1'b1;
  end

  always_comb begin
    sync_act  = (cnt < sync_end);
    blank_act = (cnt < blank_end) || (cnt >= blank_start);
  end
endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen
  import vsg_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic              hsync_i,
  output logic              hsync_o,
  output logic              hsync_oe,
  input  logic              vsync_i,
  output logic              vsync_o,
  output logic              vsync_oe,
  output logic              hmix_n,
  output logic              vmix_n
);
  logic [N_AXES-1:0][N_FIELDS-1:0][CNT_W-1:0] tim;
  ctrl_t ctrl;

  logic [CNT_W-1:0]  ax_cnt   [N_AXES];
  logic [CNT_W-1:0]  ax_total [N_AXES];
  logic [N_AXES-1:0] ax_wrap;
  logic [N_AXES-1:0] ax_sync;
  logic [N_AXES-1:0] ax_blank;
  logic [N_AXES-1:0] ax_fall;
  logic [N_AXES-1:0] ax_resync;
  logic [N_AXES-1:0] ax_adv;
  logic [N_AXES-1:0] ext_in;
  logic [N_AXES-1:0] drive;

  assign ext_in = {vsync_i, hsync_i};
  assign drive  = {ctrl.v_drive, ctrl.h_drive};

  vsg_regs #(.CNT_W(CNT_W)) i_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .tim_o  (tim),
    .ctrl_o (ctrl)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    if (a == AX_H) begin : g_adv_h
      assign ax_adv[a] = 1'b1;
    end else begin : g_adv_v
      assign ax_adv[a] = ax_wrap[AX_H];
    end

    vsg_edge_sync #(.STAGES(SYNC_STAGES)) i_esync (
      .clk  (clk),
      .rst  (rst),
      .din  (ext_in[a]),
      .fall (ax_fall[a])
    );

    assign ax_resync[a] = ax_fall[a] & ~drive[a];
    assign ax_total[a]  = tim[a][F_TOTAL];

    vsg_axis #(.CNT_W(CNT_W)) i_axis (
      .clk         (clk),
      .rst         (rst),
      .advance     (ax_adv[a]),
      .resync      (ax_resync[a]),
      .sync_end    (tim[a][F_SYNC_END]),
      .blank_end   (tim[a][F_BLANK_END]),
      .blank_start (tim[a][F_BLANK_START]),
      .total       (tim[a][F_TOTAL]),
      .cnt         (ax_cnt[a]),
      .wrap        (ax_wrap[a]),
      .sync_act    (ax_sync[a]),
      .blank_act   (ax_blank[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o  <= 1'b1;
      vsync_o  <= 1'b1;
      hsync_oe <= 1'b0;
      vsync_oe <= 1'b0;
      hmix_n   <= 1'b1;
      vmix_n   <= 1'b1;
    end else begin
      hsync_o  <= ~ax_sync[AX_H];
      vsync_o  <= ~ax_sync[AX_V];
      hsync_oe <= ctrl.h_drive;
      vsync_oe <= ctrl.v_drive;
      hmix_n   <= ctrl.csync_sel ? ~(ax_sync[AX_H] | ax_sync[AX_V])
                                 : ~ax_blank[AX_H];
      vmix_n   <= ctrl.cblank_sel ? ~(ax_blank[AX_H] | ax_blank[AX_V])
                                  : ~ax_blank[AX_V];
    end
  end
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             h_drive,
  input logic             v_drive,
  input logic             hsync_oe,
  input logic             vsync_oe,
  input logic [CNT_W-1:0] h_cnt,
  input logic [CNT_W-1:0] h_total,
  input logic             h_resync,
  input logic             h_wrap,
  input logic [CNT_W-1:0] v_cnt,
  input logic [CNT_W-1:0] v_total,
  input logic             v_resync,
  input logic             hmix_n,
  input logic             vmix_n
);
  assert_hoe_R4: assert property (@(posedge clk) disable iff (rst)
    (hsync_oe == $past(h_drive)) && (vsync_oe == $past(v_drive)));

  assert_hwrap_R1: assert property (@(posedge clk) disable iff (rst)
    (h_cnt == h_total && !h_resync) |=> (h_cnt == '0));

  assert_hstep_R1: assert property (@(posedge clk) disable iff (rst)
    (h_cnt != h_total && !h_resync) |=> (h_cnt == CNT_W'($past(h_cnt) + 1'b1)));

  assert_hresync_R5: assert property (@(posedge clk) disable iff (rst)
    h_resync |=> (h_cnt == '0));

  assert_vresync_R5: assert property (@(posedge clk) disable iff (rst)
    v_resync |=> (v_cnt == '0));

  assert_vhold_R3: assert property (@(posedge clk) disable iff (rst)
    (!h_wrap && !v_resync) |=> $stable(v_cnt));

  assert_vstep_R3: assert property (@(posedge clk) disable iff (rst)
    (h_wrap && !v_resync && v_cnt != v_total) |=> (v_cnt == CNT_W'($past(v_cnt) + 1'b1)));

  assert_reset_out_R9: assert property (@(posedge clk)
    rst |=> (!hsync_oe && !vsync_oe && hmix_n && vmix_n));
endmodule

bind video_sync_gen vsg_checker #(.CNT_W(CNT_W)) i_vsg_checker (
  .clk      (clk),
  .rst      (rst),
  .h_drive  (ctrl.h_drive),
  .v_drive  (ctrl.v_drive),
  .hsync_oe (hsync_oe),
  .vsync_oe (vsync_oe),
  .h_cnt    (ax_cnt[0]),
  .h_total  (ax_total[0]),
  .h_resync (ax_resync[0]),
  .h_wrap   (ax_wrap[0]),
  .v_cnt    (ax_cnt[1]),
  .v_total  (ax_total[1]),
  .v_resync (ax_resync[1]),
  .hmix_n   (hmix_n),
  .vmix_n   (vmix_n)
);

// File: tb/test_video_sync_gen.sv
module test_video_sync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int NVEC = 13;

  // entry: {sync_end, blank_end, blank_start, total, phase, exp hsync_o, exp hmix_n}
  localparam logic [25:0] VEC [NVEC] = '{
    {4'd3, 4'd5, 4'd12, 4'd15, 8'd0,  1'b0, 1'b0},
    {4'd3, 4'd5, 4'd12, 4'd15, 8'd2,  1'b0, 1'b0},
    {4'd3, 4'd5, 4'd12, 4'd15, 8'd3,  1'b1, 1'b0},
    {4'd3, 4'd5, 4'd12, 4'd15, 8'd5,  1'b1, 1'b1},
    {4'd3, 4'd5, 4'd12, 4'd15, 8'd11, 1'b1, 1'b1},
    {4'd3, 4'd5, 4'd12, 4'd15, 8'd12, 1'b1, 1'b0},
    {4'd3, 4'd5, 4'd12, 4'd15, 8'd15, 1'b1, 1'b0},
    {4'd3, 4'd5, 4'd12, 4'd15, 8'd16, 1'b0, 1'b0},
    {4'd3, 4'd5, 4'd12, 4'd15, 8'd19, 1'b1, 1'b0},
    {4'd1, 4'd2, 4'd6,  4'd7,  8'd8,  1'b0, 1'b0},
    {4'd1, 4'd2, 4'd6,  4'd7,  8'd9,  1'b1, 1'b0},
    {4'd1, 4'd2, 4'd6,  4'd7,  8'd2,  1'b1, 1'b1},
    {4'd1, 4'd2, 4'd6,  4'd7,  8'd6,  1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic hsync_i = 1'b1;
  logic vsync_i = 1'b1;
  logic hsync_o, hsync_oe, vsync_o, vsync_oe, hmix_n, vmix_n;

  int checks = 0;
  int fails = 0;
  int t = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  video_sync_gen #(.CNT_W(CNT_W)) i_video_sync_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hsync_i(hsync_i), .hsync_o(hsync_o), .hsync_oe(hsync_oe),
    .vsync_i(vsync_i), .vsync_o(vsync_o), .vsync_oe(vsync_oe),
    .hmix_n(hmix_n), .vmix_n(vmix_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at t=%0d: actual %b expected %b", req, t, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    t += n;
  endtask

  task automatic wr(input int addr, input int data);
    cfg_we = 1'b1;
    cfg_addr = 4'(addr);
    cfg_wdata = CNT_W'(data);
    step(1);
    cfg_we = 1'b0;
  endtask

  // Pulse external syncs low; returns at the sample that shows count zero (R5).
  task automatic align(input bit do_h, input bit do_v);
    if (do_h) hsync_i = 1'b0;
    if (do_v) vsync_i = 1'b0;
    step(2);
    hsync_i = 1'b1;
    vsync_i = 1'b1;
    step(2);
    t = 0;
  endtask

  task automatic wait_to(input int target);
    step(target - t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    step(3);
    chk("R9 hsync_o in reset", hsync_o, 1'b1);
    chk("R9 vsync_o in reset", vsync_o, 1'b1);
    chk("R9 hsync_oe in reset", hsync_oe, 1'b0);
    chk("R9 vsync_oe in reset", vsync_oe, 1'b0);
    chk("R9 hmix_n in reset", hmix_n, 1'b1);
    chk("R9 vmix_n in reset", vmix_n, 1'b1);
    rst = 1'b0;
    step(2);
    // zero limits: horizontal blank always active, composite sync would read high
    chk("R9 hmix_n carries hblank after reset", hmix_n, 1'b0);
    chk("R4 hsync_oe input mode after reset", hsync_oe, 1'b0);

    // R1 R2 R5 R11: table of horizontal limit sets and phases
    for (int i = 0; i < NVEC; i++) begin
      wr(0, int'(VEC[i][25:22]));
      wr(1, int'(VEC[i][21:18]));
      wr(2, int'(VEC[i][17:14]));
      wr(3, int'(VEC[i][13:10]));
      align(1'b1, 1'b0);
      wait_to(int'(VEC[i][9:2]));
      chk("R2 hsync_o phase", hsync_o, VEC[i][1]);
      chk("R1 R5 hmix_n hblank phase", hmix_n, VEC[i][0]);
    end

    // R3: vertical counting with 4-clock lines
    wr(0, 1); wr(1, 1); wr(2, 3); wr(3, 3);
    wr(4, 2); wr(5, 3); wr(6, 6); wr(7, 7);
    align(1'b1, 1'b1);
    chk("R3 vsync line 0", vsync_o, 1'b0);
    chk("R3 vblank line 0", vmix_n, 1'b0);
    wait_to(8);
    chk("R3 vsync line 2", vsync_o, 1'b1);
    chk("R3 vblank line 2", vmix_n, 1'b0);
    wait_to(12);
    chk("R3 vblank line 3", vmix_n, 1'b1);
    wait_to(24);
    chk("R3 vblank line 6", vmix_n, 1'b0);
    wait_to(32);
    chk("R3 vsync after vertical wrap", vsync_o, 1'b0);

    // R7 R8: composite selections
    wr(8, 4'b1100);
    align(1'b1, 1'b1);
    wait_to(1);
    chk("R7 csync low from vsync only", hmix_n, 1'b0);
    wait_to(8);
    chk("R7 csync low from hsync only", hmix_n, 1'b0);
    wait_to(9);
    chk("R7 csync high with no sync", hmix_n, 1'b1);
    wait_to(12);
    chk("R8 cblank low from hblank only", vmix_n, 1'b0);
    wait_to(13);
    chk("R8 cblank high with no blank", vmix_n, 1'b1);
    wait_to(25);
    chk("R8 cblank low from vblank only", vmix_n, 1'b0);

    // R6 R4: output mode ignores external edges
    wr(8, 0);
    wr(0, 3); wr(1, 5); wr(2, 12); wr(3, 15);
    align(1'b1, 1'b0);
    wr(8, 1);
    hsync_i = 1'b0;
    step(1);
    hsync_i = 1'b1;
    wait_to(6);
    chk("R4 hsync_oe follows drive bit", hsync_oe, 1'b1);
    chk("R4 vsync_oe stays low", vsync_oe, 1'b0);
    chk("R6 hsync_o unaffected by external edge", hsync_o, 1'b1);
    chk("R6 hblank phase unaffected", hmix_n, 1'b1);

    // R10: write to an unused address is ignored
    wr(8, 0);
    align(1'b1, 1'b0);
    wr(9, 0);
    wait_to(2);
    chk("R10 unused address write ignored", hmix_n, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule